// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block is a combinational shifter. It takes a data operand and a shift amount and produces a result with its own width. The data operand, the amount and the result each have their own width parameter. The data operand and the amount also each carry a signedness parameter. A 3-bit mode input selects the operation at run time:

- left shift, logical or arithmetic (both give the same result);
- logical right shift;
- arithmetic right shift;
- a two-way shift whose direction comes from the sign of the amount;
- a second form of the two-way shift that writes a configurable fill bit into every vacated position.

The second two-way form is meant for pulling a window out of a word, in the way an indexed part-select does. The fill bit marks the positions that fall outside the source.

The data operand is first brought to a working width equal to the larger of the operand and result widths. It is sign-extended when flagged signed and zero-extended otherwise. The working value is then shifted by a logarithmic stage chain, and the low result-width bits are driven out. Amounts at or beyond the working width saturate to a result made entirely of fill.

Top module: `shf_barrel`

## Requirements
- R1: Mode code 0 (logical left) moves the working value left by the unsigned amount and writes zero into the vacated low positions.
- R2: Mode code 2 (arithmetic left) always yields exactly the same result as mode code 0 for the same operands.
- R3: Mode code 1 (logical right) moves the working value right by the unsigned amount and writes zero into the vacated high positions.
- R4: Mode code 3 (arithmetic right) writes the top bit of the operand into the vacated high positions when the operand is configured signed, and zero when it is unsigned.
- R5: In codes 0 to 3 the amount is read as unsigned even when its top bit is set. A configuration with a signed amount used with any of these codes is flagged by an assertion.
- R6: Mode code 4 (two-way) shifts right logically when the amount is non-negative or configured unsigned. It shifts left logically by the magnitude when a signed amount is negative. Vacated positions take zero.
- R7: Mode code 5 (two-way with fill) picks its direction as code 4 does, but every vacated position takes the FILL_VALUE parameter instead of zero.
- R8: The operand is sign-extended to the working width when A_SIGNED is set and zero-extended otherwise. The result is the low Y_WIDTH bits of the shifted working value.
- R9: An amount whose magnitude is at or beyond the working width gives a result made entirely of the mode's fill: zero, the operand's sign, or FILL_VALUE.
- R10: Mode codes 6 and 7 are reserved and drive an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_WIDTH | Data operand |
| b | input | B_WIDTH | Shift amount, two's complement when B_SIGNED is set |
| mode | input | 3 | Operation select, codes as in R1 to R10 |
| y | output | Y_WIDTH | Shifted result |

## Verification
Each mode is swept over every amount code with several data patterns. An all-zero operand exposes stray fill. An alternating pattern with the top bit set separates sign fill from zero fill. A pattern with the top bit clear shows that arithmetic right fill follows the operand rather than the mode. An all-ones operand shows exactly where vacated positions begin.

Three copies of the block run side by side: signed operand with unsigned amount, signed operand with signed amount, and unsigned operand. Comparing them separates extension by signedness and reading an amount as unsigned from reading it as negative. All outputs are compared with a model built from the language's own shift operators plus a computed vacated-position mask. That model covers the saturating amounts above the working width.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    SHF_LSL   = 3'd0,
    SHF_LSR   = 3'd1,
    SHF_ASL   = 3'd2,
    SHF_ASR   = 3'd3,
    SHF_BIDIR = 3'd4,
    SHF_BIFIL = 3'd5,
    SHF_RSV6  = 3'd6,
    SHF_RSV7  = 3'd7
  } shf_mode_e;

  function automatic logic shf_is_std(input shf_mode_e m);
    return (m == SHF_LSL) || (m == SHF_LSR) || (m == SHF_ASL) || (m == SHF_ASR);
  endfunction

endpackage

// File: rtl/shf_extend.sv
module shf_extend #(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 12,
  parameter bit SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic pad_bit;
      assign pad_bit = SIGNED ? din[IN_W-1] : 1'b0;
      assign dout    = {{PAD_W{pad_bit}}, din};
    end else begin : g_same
      assign dout = din[OUT_W-1:0];
    end
  endgenerate

  // R8
  always_comb begin
    ext_low_chk: assert (dout[IN_W-1:0] == din)
      else $error("extension changed the low operand bits");
  end

endmodule

// File: rtl/shf_amount.sv
module shf_amount #(
  parameter int B_W    = 4,
  parameter bit B_SGN  = 1'b0,
  parameter int WORK_W = 12
) (
  input  logic [B_W-1:0]                b,
  input  logic                          two_way,
  output logic                          neg,
  output logic [$clog2(WORK_W)-1:0]     sh,
  output logic                          over
);
  localparam int SH_W = $clog2(WORK_W);
  localparam int MW   = (B_W + 1 > SH_W) ? B_W + 1 : SH_W;

  logic [MW-1:0] b_wide;
  logic [MW-1:0] mag;

  always_comb begin
    neg    = B_SGN && two_way && b[B_W-1];
    b_wide = {{(MW-B_W){neg}}, b};
    mag    = neg ? (MW'(0) - b_wide) : b_wide;
    over   = (mag >= MW'(WORK_W));
    sh     = mag[SH_W-1:0];
  end

  // R6
  always_comb begin
    zero_amt_chk: assert (b != '0 || (!neg && !over && sh == '0))
      else $error("zero amount decoded as a shift");
  end

endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int W = 12
) (
  input  logic [W-1:0]          din,
  input  logic [$clog2(W)-1:0]  sh,
  input  logic                  over,
  input  logic                  left,
  input  logic                  fill,
  output logic [W-1:0]          dout
);
  localparam int STAGES = $clog2(W);

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [W-1:0] stg [STAGES+1];
  logic [W-1:0] shifted;

  assign stg[0] = left ? flip(din) : din;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int D = 1 << s;
      assign stg[s+1] = sh[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
    end
  endgenerate

  always_comb begin
    shifted = over ? {W{fill}} : stg[STAGES];
    dout    = left ? flip(shifted) : shifted;
  end

  // R9
  always_comb begin
    sat_fill_chk: assert (!over || dout == {W{fill}})
      else $error("saturated shift left operand bits");
  end

  // R1
  always_comb begin
    no_shift_chk: assert (over || sh != '0 || dout == din)
      else $error("zero shift altered the data");
  end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int A_WIDTH    = 8,
  parameter bit A_SIGNED   = 1'b1,
  parameter int B_WIDTH    = 4,
  parameter bit B_SIGNED   = 1'b0,
  parameter int Y_WIDTH    = 12,
  parameter bit FILL_VALUE = 1'b1
) (
  input  logic [A_WIDTH-1:0] a,
  input  logic [B_WIDTH-1:0] b,
  input  logic [2:0]         mode,
  output logic [Y_WIDTH-1:0] y
);
  import shf_pkg::*;

  localparam int WORK_W = (A_WIDTH > Y_WIDTH) ? A_WIDTH : Y_WIDTH;
  localparam int SH_W   = $clog2(WORK_W);

  shf_mode_e        m;
  logic [WORK_W-1:0] a_work;
  logic [WORK_W-1:0] shifted;
  logic [SH_W-1:0]  sh;
  logic             over;
  logic             neg;
  logic             two_way;
  logic             left;
  logic             fill;
  logic             rsv;

  assign m = shf_mode_e'(mode);

  shf_extend #(.IN_W(A_WIDTH), .OUT_W(WORK_W), .SIGNED(A_SIGNED)) u_ext (
    .din (a),
    .dout(a_work)
  );

  always_comb begin
    two_way = (m == SHF_BIDIR) || (m == SHF_BIFIL);
    rsv     = (m == SHF_RSV6) || (m == SHF_RSV7);
  end

  shf_amount #(.B_W(B_WIDTH), .B_SGN(B_SIGNED), .WORK_W(WORK_W)) u_amt (
    .b      (b),
    .two_way(two_way),
    .neg    (neg),
    .sh     (sh),
    .over   (over)
  );

  always_comb begin
    left = 1'b0;
    fill = 1'b0;
    unique case (m)
      SHF_LSL, SHF_ASL: left = 1'b1;
      SHF_ASR:          fill = A_SIGNED ? a_work[WORK_W-1] : 1'b0;
      SHF_BIDIR:        left = neg;
      SHF_BIFIL: begin
        left = neg;
        fill = FILL_VALUE;
      end
      default: ;
    endcase
  end

  shf_core #(.W(WORK_W)) u_core (
    .din  (a_work),
    .sh   (sh),
    .over (over),
    .left (left),
    .fill (fill),
    .dout (shifted)
  );

  assign y = rsv ? '0 : shifted[Y_WIDTH-1:0];

  // R5
  always_comb begin
    amt_sign_cfg_chk: assert (!(B_SIGNED && shf_is_std(m)))
      else $error("signed amount used with a standard shift code");
  end

  // R10
  always_comb begin
    rsv_zero_chk: assert (!(mode[2] && mode[1]) || y == '0)
      else $error("reserved code gave a nonzero result");
  end

endmodule

// File: tb/shf_barrel_tb.sv
module shf_barrel_tb;
  localparam int AW = 8;
  localparam int BW = 4;
  localparam int YW = 12;
  localparam int WW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] a;
  logic [BW-1:0] b;
  logic [2:0]    mode;
  logic [2:0]    mode_s;
  logic [YW-1:0] y, y_s, y_u;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  shf_barrel #(.A_WIDTH(AW), .A_SIGNED(1'b1), .B_WIDTH(BW), .B_SIGNED(1'b0),
               .Y_WIDTH(YW), .FILL_VALUE(1'b1)) u_dut (
    .a(a), .b(b), .mode(mode), .y(y));

  shf_barrel #(.A_WIDTH(AW), .A_SIGNED(1'b1), .B_WIDTH(BW), .B_SIGNED(1'b1),
               .Y_WIDTH(YW), .FILL_VALUE(1'b1)) u_dut_s (
    .a(a), .b(b), .mode(mode_s), .y(y_s));

  shf_barrel #(.A_WIDTH(AW), .A_SIGNED(1'b0), .B_WIDTH(BW), .B_SIGNED(1'b0),
               .Y_WIDTH(YW), .FILL_VALUE(1'b1)) u_dut_u (
    .a(a), .b(b), .mode(mode), .y(y_u));

  function automatic logic [YW-1:0] ref_y(input logic [AW-1:0] av, input logic [BW-1:0] bv,
                                          input int md, input bit asg, input bit bsg);
    logic [WW-1:0] ext;
    logic [WW-1:0] r;
    logic [WW-1:0] ones;
    int amt;
    bit lft;
    ones = '1;
    ext  = asg ? {{(WW-AW){av[AW-1]}}, av} : {{(WW-AW){1'b0}}, av};
    amt  = int'(bv);
    lft  = 1'b0;
    r    = '0;
    case (md)
      0, 2: r = ext << amt;
      1:    r = ext >> amt;
      3:    r = asg ? WW'($signed(ext) >>> amt) : (ext >> amt);
      4, 5: begin
        if (bsg && bv[BW-1]) begin
          amt = (1 << BW) - int'(bv);
          lft = 1'b1;
        end
        r = lft ? (ext << amt) : (ext >> amt);
        if (md == 5) r = r | (lft ? ~(ones << amt) : ~(ones >> amt));
      end
      default: r = '0;
    endcase
    return r[YW-1:0];
  endfunction

  task automatic check(input logic [YW-1:0] act, input logic [YW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h mode=%0d actual=%h expected=%h", req, a, b, mode, act, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] av, input logic [BW-1:0] bv,
                       input logic [2:0] md, input logic [2:0] mds);
    @(posedge clk);
    #1;
    a = av; b = bv; mode = md; mode_s = mds;
    @(negedge clk);
  endtask

  task automatic sweep(input int md, input logic [AW-1:0] av, input string req);
    for (int k = 0; k < (1 << BW); k++) begin
      apply(av, BW'(k), 3'(md), 3'd4);
      check(y, ref_y(av, BW'(k), md, 1'b1, 1'b0), req);
      check(y_u, ref_y(av, BW'(k), md, 1'b0, 1'b0), req);
    end
  endtask

  task automatic t_zero;
    apply('0, '0, 3'd0, 3'd4);
    check(y, '0, "R1 zero operand");
    check(y_s, '0, "R6 zero operand");
  endtask

  task automatic t_left;
    sweep(0, 8'hA5, "R1");
    sweep(0, 8'hFF, "R1");
  endtask

  task automatic t_asl_same;
    for (int k = 0; k < (1 << BW); k++) begin
      logic [YW-1:0] lsl_y;
      apply(8'hC3, BW'(k), 3'd0, 3'd4);
      lsl_y = y;
      apply(8'hC3, BW'(k), 3'd2, 3'd4);
      check(y, lsl_y, "R2 asl equals lsl");
    end
    sweep(2, 8'h5A, "R2");
  endtask

  task automatic t_right;
    sweep(1, 8'h81, "R3");
    sweep(1, 8'h7F, "R3");
  endtask

  task automatic t_asr;
    sweep(3, 8'h81, "R4");
    sweep(3, 8'h7F, "R4");
    apply(8'h80, 4'd3, 3'd3, 3'd4);
    check(y, 12'hFF0, "R4 signed sign fill");
    check(y_u, 12'h010, "R4 unsigned zero fill");
  endtask

  task automatic t_unsigned_amt;
    apply(8'h01, 4'd9, 3'd0, 3'd4);
    check(y, 12'h200, "R5 amount 9 read unsigned");
    apply(8'hF0, 4'd9, 3'd1, 3'd4);
    check(y, 12'h007, "R5 amount 9 read unsigned");
  endtask

  task automatic t_bidir;
    for (int k = 0; k < (1 << BW); k++) begin
      apply(8'hB6, BW'(k), 3'd4, 3'd4);
      check(y, ref_y(8'hB6, BW'(k), 4, 1'b1, 1'b0), "R6 unsigned amount");
      check(y_s, ref_y(8'hB6, BW'(k), 4, 1'b1, 1'b1), "R6 signed amount");
    end
    apply(8'h01, 4'hD, 3'd4, 3'd4);
    check(y_s, 12'h008, "R6 minus three goes left");
    check(y, 12'h000, "R6 unsigned 13 goes right");
  endtask

  task automatic t_bifil;
    for (int k = 0; k < (1 << BW); k++) begin
      apply(8'h3C, BW'(k), 3'd5, 3'd5);
      check(y, ref_y(8'h3C, BW'(k), 5, 1'b1, 1'b0), "R7 unsigned amount");
      check(y_s, ref_y(8'h3C, BW'(k), 5, 1'b1, 1'b1), "R7 signed amount");
    end
    apply(8'h00, 4'd4, 3'd5, 3'd5);
    check(y, 12'hF00, "R7 right fill");
    apply(8'h00, 4'hE, 3'd5, 3'd5);
    check(y_s, 12'h003, "R7 left fill");
  endtask

  task automatic t_extend;
    apply(8'h9A, 4'd0, 3'd1, 3'd4);
    check(y, 12'hF9A, "R8 sign extension");
    check(y_u, 12'h09A, "R8 zero extension");
  endtask

  task automatic t_saturate;
    for (int k = WW; k < (1 << BW); k++) begin
      apply(8'h80, BW'(k), 3'd3, 3'd5);
      check(y, 12'hFFF, "R9 asr sign saturation");
      check(y_u, 12'h000, "R9 asr unsigned saturation");
      apply(8'hFF, BW'(k), 3'd5, 3'd5);
      check(y, 12'hFFF, "R9 fill saturation");
      apply(8'hFF, BW'(k), 3'd0, 3'd4);
      check(y, 12'h000, "R9 left saturation");
    end
  endtask

  task automatic t_reserved;
    apply(8'hFF, 4'd1, 3'd6, 3'd4);
    check(y, '0, "R10 code 6");
    apply(8'h81, 4'd0, 3'd7, 3'd4);
    check(y, '0, "R10 code 7");
  endtask

  initial begin
    a = '0; b = '0; mode = 3'd0; mode_s = 3'd4;
    repeat (2) @(posedge clk);
    t_zero();
    t_left();
    t_asl_same();
    t_right();
    t_asr();
    t_unsigned_amt();
    t_bidir();
    t_bifil();
    t_extend();
    t_saturate();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule